// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Core

This block turns an addressing-mode code, the operand bytes that follow an opcode, the two index registers and the program counter into the 16-bit address that an 8-bit processor's execute stage will use. Modes that need no memory access finish one clock after the request. The three pointer modes fetch a little-endian pointer through a byte-wide synchronous read port. The result is always reported with a one-cycle `done` pulse.

The unit also flags when an index add or a branch offset moves the address into a different 256-byte page. It raises an error for mode codes that are not defined, and for the Y-indexed zero-page form when that form is used by anything other than the X-register load or store. A requester raises `start` for one cycle with the operands valid, waits for `done`, and takes `ea`, `page_cross` and `err` in that cycle.

Top module: `effaddr_unit`

## Requirements
- R1: After reset, `done`, `mem_rd`, `err` and `page_cross` are low and `ea` and `mem_addr` are zero.
- R2: Non-memory modes (codes 0 to 9) assert `done` for one cycle after the rising edge that samples `start` and never assert `mem_rd`. Implied (code 0) and accumulator (code 1) give `ea` = 0. Immediate (code 2) gives `ea` = `pc` - 1, because `pc` already points past the operand byte.
- R3: Zero page (code 3) gives `ea` = {8'h00, `op_lo`}.
- R4: Zero page indexed by X (code 4) and by Y (code 5) give {8'h00, (`op_lo` + index) mod 256}. For example, $80 plus $FF gives $007F.
- R5: Code 5 with `op_xfer` low, and codes 13 to 15, raise `err` together with `done`, with `ea` = 0 and no memory read.
- R6: Relative (code 6) adds `op_lo` as a signed byte to `pc`, which is already advanced past the two-byte branch.
- R7: Absolute (code 7) gives {`op_hi`, `op_lo`}. Absolute X (code 8) and absolute Y (code 9) add the unsigned index to that 16-bit word.
- R8: Indirect (code 10) reads the low byte at {`op_hi`, `op_lo`} and the high byte at the next address, using a full 16-bit increment. The result is {high, low}.
- R9: Indexed indirect (code 11) reads the pointer at zero-page location (`op_lo` + X) mod 256. The high byte comes from the next location, wrapped within page zero, so $FF is followed by $00.
- R10: Indirect indexed (code 12) reads the pointer at zero-page `op_lo` (high byte at (`op_lo` + 1) mod 256), then adds Y to the pointer.
- R11: Pointer modes hold `mem_rd` high for exactly two consecutive cycles starting one cycle after `start` (low address first). Read data is taken one cycle after each read. `done` rises at the fourth rising edge, counting the edge that samples `start` as the first, and is never high together with `mem_rd`.
- R12: A `start` raised while a pointer fetch is in progress is ignored: it produces no extra `done` and does not change the pending result.
- R13: `page_cross` is high only with `done`, and only in codes 6, 8, 9 and 12 when the upper byte of the result differs from the upper byte of the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one cycle |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| x | input | 8 | X index register |
| y | input | 8 | Y index register |
| pc | input | 16 | Program counter, already past the instruction |
| op_xfer | input | 1 | Operation is the X-register load or store |
| mem_addr | output | 16 | Pointer read address |
| mem_rd | output | 1 | Pointer read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| ea | output | 16 | Effective address, valid with `done` |
| done | output | 1 | Result pulse |
| page_cross | output | 1 | Index or offset changed the page |
| err | output | 1 | Illegal mode for this operation |

## Verification
The assertions assume that the memory answers every read with data one cycle later, and that operands are held steady in the cycle where `start` is sampled. The check that a non-memory request is acknowledged at once is gated on the sequencer being idle, so that a `start` overlapping a pointer fetch does not trip it. The stimulus raises `start` only when the unit is idle, with one deliberate exception: a single overlapping request that exercises R12. The bench memory model returns an address-derived byte and answers every read one cycle later.

// File: rtl/effaddr_pkg.sv
package effaddr_pkg;

   typedef enum logic [3:0] {
      AM_IMPL = 4'd0,
      AM_ACC  = 4'd1,
      AM_IMM  = 4'd2,
      AM_ZP   = 4'd3,
      AM_ZPX  = 4'd4,
      AM_ZPY  = 4'd5,
      AM_REL  = 4'd6,
      AM_ABS  = 4'd7,
      AM_ABSX = 4'd8,
      AM_ABSY = 4'd9,
      AM_IND  = 4'd10,
      AM_XIND = 4'd11,
      AM_INDY = 4'd12
   } amode_e;

   typedef enum logic [1:0] {
      PS_IDLE,
      PS_LO,
      PS_HI,
      PS_FIN
   } pstate_e;

endpackage

// File: rtl/effaddr_index_add.sv
// Adds an index or signed offset byte to a full address and reports
// whether the upper part of the address changed.
module effaddr_index_add #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [AW-1:0] base_i,
   input  logic [DW-1:0] off_i,
   input  logic          sgn_i,
   output logic [AW-1:0] sum_o,
   output logic          cross_o
);
   localparam int HW = AW - DW;

   logic [AW-1:0] ext;

   always_comb begin
      if (sgn_i) ext = {{HW{off_i[DW-1]}}, off_i};
      else       ext = {{HW{1'b0}}, off_i};
      sum_o   = base_i + ext;
      cross_o = (sum_o[AW-1:DW] != base_i[AW-1:DW]);
   end
endmodule

// File: rtl/effaddr_direct.sv
// Single-cycle address formation for the modes that need no memory,
// plus pointer-address formation for the three fetching modes.
module effaddr_direct
   import effaddr_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter bit ZP_PTR_WRAP = 1'b1
) (
   input  logic [3:0]    mode_i,
   input  logic [DW-1:0] op_lo_i,
   input  logic [DW-1:0] op_hi_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] y_i,
   input  logic [AW-1:0] pc_i,
   input  logic          xfer_i,
   output logic [AW-1:0] ea_o,
   output logic          cross_o,
   output logic          err_o,
   output logic          mem_o,
   output logic [AW-1:0] ptr0_o,
   output logic [AW-1:0] ptr1_o,
   output logic          idx_o
);
   localparam int HW = AW - DW;

   logic [AW-1:0] abs_w;
   logic [DW-1:0] zp_x, zp_y;
   logic [AW-1:0] zx_next, zl_next;
   logic [AW-1:0] add_base;
   logic [DW-1:0] add_off;
   logic          add_sgn, use_add;
   logic [AW-1:0] add_sum;
   logic          add_cross;

   assign abs_w = {op_hi_i, op_lo_i};
   assign zp_x  = op_lo_i + x_i;
   assign zp_y  = op_lo_i + y_i;

   // Location of the pointer high byte for the zero-page pointer modes.
   generate
      if (ZP_PTR_WRAP) begin : g_zp_wrap
         assign zx_next = {{HW{1'b0}}, DW'(zp_x + 1'b1)};
         assign zl_next = {{HW{1'b0}}, DW'(op_lo_i + 1'b1)};
      end else begin : g_zp_carry
         assign zx_next = {{HW{1'b0}}, zp_x} + AW'(1);
         assign zl_next = {{HW{1'b0}}, op_lo_i} + AW'(1);
      end
   endgenerate

   // Adder steering: branch offset or absolute index.
   always_comb begin
      use_add  = 1'b0;
      add_base = abs_w;
      add_off  = x_i;
      add_sgn  = 1'b0;
      case (mode_i)
         AM_REL: begin
            use_add  = 1'b1;
            add_base = pc_i;
            add_off  = op_lo_i;
            add_sgn  = 1'b1;
         end
         AM_ABSX: use_add = 1'b1;
         AM_ABSY: begin
            use_add = 1'b1;
            add_off = y_i;
         end
         default: use_add = 1'b0;
      endcase
   end

   effaddr_index_add #(.AW(AW), .DW(DW)) u_add (
      .base_i  (add_base),
      .off_i   (add_off),
      .sgn_i   (add_sgn),
      .sum_o   (add_sum),
      .cross_o (add_cross)
   );

   always_comb begin
      ea_o    = '0;
      cross_o = 1'b0;
      err_o   = 1'b0;
      mem_o   = 1'b0;
      ptr0_o  = '0;
      ptr1_o  = '0;
      idx_o   = 1'b0;
      case (mode_i)
         AM_IMPL, AM_ACC: ea_o = '0;
         AM_IMM:  ea_o = pc_i - AW'(1);
         AM_ZP:   ea_o = {{HW{1'b0}}, op_lo_i};
         AM_ZPX:  ea_o = {{HW{1'b0}}, zp_x};
         AM_ZPY: begin
            if (xfer_i) ea_o = {{HW{1'b0}}, zp_y};
            else        err_o = 1'b1;
         end
         AM_ABS:  ea_o = abs_w;
         AM_REL, AM_ABSX, AM_ABSY: ea_o = '0;
         AM_IND: begin
            mem_o  = 1'b1;
            ptr0_o = abs_w;
            ptr1_o = abs_w + AW'(1);
         end
         AM_XIND: begin
            mem_o  = 1'b1;
            ptr0_o = {{HW{1'b0}}, zp_x};
            ptr1_o = zx_next;
         end
         AM_INDY: begin
            mem_o  = 1'b1;
            ptr0_o = {{HW{1'b0}}, op_lo_i};
            ptr1_o = zl_next;
            idx_o  = 1'b1;
         end
         default: err_o = 1'b1;
      endcase
      if (use_add) begin
         ea_o    = add_sum;
         cross_o = add_cross;
      end
   end
endmodule

// File: rtl/effaddr_ptr_seq.sv
// Two-read pointer fetch with an optional post-index by Y.
module effaddr_ptr_seq
   import effaddr_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [AW-1:0] ptr0_i,
   input  logic [AW-1:0] ptr1_i,
   input  logic          idx_i,
   input  logic [DW-1:0] y_i,
   input  logic [DW-1:0] rdata_i,
   output logic          busy_o,
   output logic          rd_o,
   output logic [AW-1:0] addr_o,
   output logic          fin_o,
   output logic [AW-1:0] ea_o,
   output logic          cross_o
);
   pstate_e       st;
   logic [AW-1:0] p1_q;
   logic          idx_q;
   logic [DW-1:0] y_q;
   logic [DW-1:0] lo_q;
   logic [AW-1:0] ptr_w;
   logic [AW-1:0] sum_w;
   logic          cr_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PS_IDLE;
         rd_o   <= 1'b0;
         addr_o <= '0;
         p1_q   <= '0;
         idx_q  <= 1'b0;
         y_q    <= '0;
         lo_q   <= '0;
      end else begin
         case (st)
            PS_IDLE: begin
               if (go_i) begin
                  st     <= PS_LO;
                  rd_o   <= 1'b1;
                  addr_o <= ptr0_i;
                  p1_q   <= ptr1_i;
                  idx_q  <= idx_i;
                  y_q    <= y_i;
               end
            end
            PS_LO: begin
               st     <= PS_HI;
               addr_o <= p1_q;
            end
            PS_HI: begin
               st   <= PS_FIN;
               rd_o <= 1'b0;
               lo_q <= rdata_i;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   // In PS_FIN the read data bus carries the high pointer byte.
   assign ptr_w = {rdata_i, lo_q};

   effaddr_index_add #(.AW(AW), .DW(DW)) u_post (
      .base_i  (ptr_w),
      .off_i   (y_q),
      .sgn_i   (1'b0),
      .sum_o   (sum_w),
      .cross_o (cr_w)
   );

   assign busy_o  = (st != PS_IDLE);
   assign fin_o   = (st == PS_FIN);
   assign ea_o    = idx_q ? sum_w : ptr_w;
   assign cross_o = idx_q & cr_w;
endmodule

// File: rtl/effaddr_unit.sv
module effaddr_unit
   import effaddr_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter bit ZP_PTR_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [DW-1:0] op_lo,
   input  logic [DW-1:0] op_hi,
   input  logic [DW-1:0] x,
   input  logic [DW-1:0] y,
   input  logic [AW-1:0] pc,
   input  logic          op_xfer,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] ea,
   output logic          done,
   output logic          page_cross,
   output logic          err
);
   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("effaddr_unit: AW must be twice DW");
      end
      if (DW < 2) begin : g_bad_dw
         $error("effaddr_unit: DW must be at least 2");
      end
   endgenerate

   logic [AW-1:0] d_ea, d_ptr0, d_ptr1;
   logic          d_cross, d_err, d_mem, d_idx;
   logic          seq_busy, seq_fin, seq_cross, seq_go;
   logic [AW-1:0] seq_ea;
   logic          take;

   effaddr_direct #(.AW(AW), .DW(DW), .ZP_PTR_WRAP(ZP_PTR_WRAP)) u_direct (
      .mode_i  (mode),
      .op_lo_i (op_lo),
      .op_hi_i (op_hi),
      .x_i     (x),
      .y_i     (y),
      .pc_i    (pc),
      .xfer_i  (op_xfer),
      .ea_o    (d_ea),
      .cross_o (d_cross),
      .err_o   (d_err),
      .mem_o   (d_mem),
      .ptr0_o  (d_ptr0),
      .ptr1_o  (d_ptr1),
      .idx_o   (d_idx)
   );

   assign take   = start & ~seq_busy;
   assign seq_go = take & d_mem;

   effaddr_ptr_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (seq_go),
      .ptr0_i  (d_ptr0),
      .ptr1_i  (d_ptr1),
      .idx_i   (d_idx),
      .y_i     (y),
      .rdata_i (mem_rdata),
      .busy_o  (seq_busy),
      .rd_o    (mem_rd),
      .addr_o  (mem_addr),
      .fin_o   (seq_fin),
      .ea_o    (seq_ea),
      .cross_o (seq_cross)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea         <= '0;
         done       <= 1'b0;
         page_cross <= 1'b0;
         err        <= 1'b0;
      end else if (seq_fin) begin
         ea         <= seq_ea;
         done       <= 1'b1;
         page_cross <= seq_cross;
         err        <= 1'b0;
      end else if (take && !d_mem) begin
         ea         <= d_ea;
         done       <= 1'b1;
         page_cross <= d_cross;
         err        <= d_err;
      end else begin
         done       <= 1'b0;
         page_cross <= 1'b0;
         err        <= 1'b0;
      end
   end
endmodule

// File: rtl/effaddr_unit_chk.sv
module effaddr_unit_chk
   import effaddr_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [3:0]    mode,
   input logic [DW-1:0] op_lo,
   input logic [DW-1:0] x,
   input logic [AW-1:0] pc,
   input logic          mem_rd,
   input logic [AW-1:0] ea,
   input logic          done,
   input logic          page_cross,
   input logic          err,
   input logic          seq_busy
);
   // R2
   nonmem_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !seq_busy && mode <= 4'd9) |=> (done && !mem_rd));

   // R4
   zpx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !seq_busy && mode == AM_ZPX) |=>
      (ea[AW-1:DW] == '0 && ea[DW-1:0] == DW'($past(op_lo) + $past(x))));

   // R6
   rel_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !seq_busy && mode == AM_REL) |=>
      (ea == $past(pc) + AW'($signed($past(op_lo)))));

   // R11
   rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |=> mem_rd);

   // R11
   rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |=> !mem_rd);

   // R11
   rd_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd);

   // R5
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && ea == '0));

   // R13
   cross_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_cross |-> done);
endmodule

bind effaddr_unit effaddr_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/effaddr_unit_test.sv
module effaddr_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [7:0]  op_lo = '0, op_hi = '0, x = '0, y = '0;
   logic [15:0] pc = '0;
   logic        op_xfer = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata = '0;
   logic [15:0] ea;
   logic        done, page_cross, err;

   int checks = 0;
   int errors = 0;
   int nrd = 0;
   logic [15:0] rd_log [4];
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   effaddr_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_lo(op_lo), .op_hi(op_hi), .x(x), .y(y), .pc(pc),
      .op_xfer(op_xfer), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .ea(ea), .done(done),
      .page_cross(page_cross), .err(err)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      if (a == 16'h0120) return 8'hFC;
      if (a == 16'h0121) return 8'hBA;
      return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ 8'h3C;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= memf(mem_addr);
         if (nrd < 4) rd_log[nrd] = mem_addr;
         nrd = nrd + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                      input logic [7:0] xv, input logic [7:0] yv, input logic [15:0] p,
                      input logic xf, input string tag);
      logic [15:0] e_ea, p0, p1, base;
      logic e_cr, e_err, e_mem;
      logic [7:0] zp;
      int lat;
      e_ea = '0; e_cr = 0; e_err = 0; e_mem = 0; p0 = '0; p1 = '0;
      case (m)
         4'd0, 4'd1: e_ea = '0;
         4'd2: e_ea = p - 16'd1;
         4'd3: e_ea = {8'h00, lo};
         4'd4: e_ea = {8'h00, 8'(lo + xv)};
         4'd5: if (xf) e_ea = {8'h00, 8'(lo + yv)}; else e_err = 1;
         4'd6: begin
            e_ea = p + {{8{lo[7]}}, lo};
            e_cr = e_ea[15:8] != p[15:8];
         end
         4'd7: e_ea = {hi, lo};
         4'd8, 4'd9: begin
            e_ea = {hi, lo} + {8'h00, (m == 4'd8) ? xv : yv};
            e_cr = e_ea[15:8] != hi;
         end
         4'd10: begin
            e_mem = 1; p0 = {hi, lo}; p1 = p0 + 16'd1;
            e_ea = {memf(p1), memf(p0)};
         end
         4'd11: begin
            e_mem = 1; zp = 8'(lo + xv);
            p0 = {8'h00, zp}; p1 = {8'h00, 8'(zp + 8'd1)};
            e_ea = {memf(p1), memf(p0)};
         end
         4'd12: begin
            e_mem = 1; p0 = {8'h00, lo}; p1 = {8'h00, 8'(lo + 8'd1)};
            base = {memf(p1), memf(p0)};
            e_ea = base + {8'h00, yv};
            e_cr = e_ea[15:8] != base[15:8];
         end
         default: e_err = 1;
      endcase
      @(negedge clk);
      mode = m; op_lo = lo; op_hi = hi; x = xv; y = yv; pc = p; op_xfer = xf;
      start = 1; nrd = 0;
      @(negedge clk);
      start = 0; lat = 1;
      while (!done && lat < 8) begin
         @(negedge clk);
         lat++;
      end
      // R2 / R11: latency, R13: page flag, R5: error flag
      chk({tag, " latency"}, lat, e_mem ? 4 : 1);
      chk({tag, " ea"}, ea, e_ea);
      chk({tag, " R13 page_cross"}, page_cross, e_cr);
      chk({tag, " R5 err"}, err, e_err);
      chk({tag, " R11 read count"}, nrd, e_mem ? 2 : 0);
      if (e_mem && nrd == 2) begin
         chk({tag, " R11 first read addr"}, rd_log[0], p0);
         chk({tag, " R11 second read addr"}, rd_log[1], p1);
      end
      @(negedge clk);
      chk({tag, " done pulse width"}, done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 done", done, 0);
      chk("R1 mem_rd", mem_rd, 0);
      chk("R1 err", err, 0);
      chk("R1 page_cross", page_cross, 0);
      chk("R1 ea", ea, 0);
      chk("R1 mem_addr", mem_addr, 0);
      rst_n = 1;

      // R2: implied, accumulator, immediate
      for (int i = 0; i < 4; i++) begin
         logic [15:0] pv;
         pv = (i == 0) ? 16'h0000 : (i == 1) ? 16'h0001 : (i == 2) ? 16'h8000 : 16'hFFFF;
         run(4'd0, 8'h55, 8'hAA, 8'h11, 8'h22, pv, 0, "R2 implied");
         run(4'd1, 8'h55, 8'hAA, 8'h11, 8'h22, pv, 0, "R2 accum");
         run(4'd2, 8'h55, 8'hAA, 8'h11, 8'h22, pv, 0, "R2 immediate");
      end

      // R3: zero page, every operand
      for (int l = 0; l < 256; l++)
         run(4'd3, 8'(l), 8'hC3, 8'h40, 8'h41, 16'h1234, 0, "R3 zp");

      // R4: zero page indexed with wrap, stated example first
      run(4'd4, 8'h80, 8'h00, 8'hFF, 8'h00, 16'h0, 0, "R4 zpx 80+FF");
      for (int l = 0; l < 256; l++)
         for (int v = 0; v < 256; v += 51) begin
            run(4'd4, 8'(l), 8'h12, 8'(v), 8'h00, 16'h0, 0, "R4 zpx");
            run(4'd5, 8'(l), 8'h12, 8'h00, 8'(v), 16'h0, 1, "R4 zpy");
         end

      // R5: zero page Y outside the X transfer, undefined codes
      run(4'd5, 8'h10, 8'h00, 8'h00, 8'h05, 16'h0, 0, "R5 zpy other op");
      run(4'd5, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h0, 0, "R5 zpy other op");
      for (int c = 13; c < 16; c++)
         run(4'(c), 8'h10, 8'h20, 8'h01, 8'h02, 16'h4000, 1, "R5 undefined code");

      // R6: relative, all offsets at several counters
      for (int i = 0; i < 5; i++) begin
         logic [15:0] pv;
         pv = (i == 0) ? 16'h0000 : (i == 1) ? 16'h1280 : (i == 2) ? 16'h12FE :
              (i == 3) ? 16'h8000 : 16'hFFFF;
         for (int l = 0; l < 256; l++)
            run(4'd6, 8'(l), 8'h00, 8'h00, 8'h00, pv, 0, "R6 relative");
      end

      // R7: absolute and absolute indexed, stated example first
      run(4'd8, 8'h00, 8'h20, 8'h92, 8'h00, 16'h0, 0, "R7 absx 2000+92");
      for (int h = 0; h < 256; h += 37)
         for (int l = 0; l < 256; l += 29) begin
            run(4'd7, 8'(l), 8'(h), 8'h00, 8'h00, 16'h0, 0, "R7 abs");
            for (int v = 0; v < 256; v += 51) begin
               run(4'd8, 8'(l), 8'(h), 8'(v), 8'h00, 16'h0, 0, "R7 absx");
               run(4'd9, 8'(l), 8'(h), 8'h00, 8'(v), 16'h0, 0, "R7 absy");
            end
         end
      run(4'd8, 8'hFF, 8'hFF, 8'h01, 8'h00, 16'h0, 0, "R7 absx top wrap");

      // R8: indirect, stated example and page-edge pointers
      run(4'd10, 8'h20, 8'h01, 8'h00, 8'h00, 16'h0, 0, "R8 ind 0120");
      chk("R8 ind 0120 value", ea, 16'hBAFC);
      run(4'd10, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0, 0, "R8 ind page edge");
      run(4'd10, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0, 0, "R8 ind top");
      for (int h = 0; h < 256; h += 85)
         for (int l = 0; l < 256; l += 15)
            run(4'd10, 8'(l), 8'(h), 8'h00, 8'h00, 16'h0, 0, "R8 ind");

      // R9 and R10: zero-page pointer modes, every operand
      for (int l = 0; l < 256; l++)
         for (int v = 0; v < 256; v += 51) begin
            run(4'd11, 8'(l), 8'h00, 8'(v), 8'h00, 16'h0, 0, "R9 xind");
            run(4'd12, 8'(l), 8'h00, 8'h00, 8'(v), 16'h0, 0, "R10 indy");
         end

      // R12: second start during a pointer fetch is dropped
      begin
         int ndone;
         @(negedge clk);
         mode = 4'd10; op_lo = 8'h20; op_hi = 8'h01; start = 1; nrd = 0;
         @(negedge clk);
         mode = 4'd3; op_lo = 8'h33;
         @(negedge clk);
         start = 0; ndone = 0;
         for (int k = 0; k < 6; k++) begin
            if (done) begin
               ndone++;
               chk("R12 pending result kept", ea, 16'hBAFC);
            end
            @(negedge clk);
         end
         chk("R12 single done", ndone, 1);
         chk("R12 read count", nrd, 2);
      end

      summary();
   end
endmodule